// File: doc/BRIEF.md
# DS3 Receive Framing Status and Reframe Controller

This block sits beside a DS3 receive framer core and gives the processor its view of framing. It follows the core's frame-lock level and keeps an out-of-frame flag. The flag drives an output pin and appears in a read-only receive status register, next to externally supplied AIS, LOS and idle indications. Every change of the out-of-frame state, into or out of it, latches a sticky interrupt flag. A separate enable bit gates that flag onto the interrupt pin.

Software can force a reframe through a self-clearing command bit. The block then sends a one-cycle pulse to the core, which returns to F-bit search, and declares out-of-frame at once. A saturating 16-bit counter counts framing-bit error pulses (F and M bits) from the core. The processor reads the counter as two bytes. The high-byte read takes a snapshot of the count and restarts it. The low-byte read returns the rest of that snapshot.

Top module: `ds3_frm_status`

## Requirements
- R1: After reset, oof_o is 1, irq_o and reframe_o are 0, the control register (0x01) reads 0xA0, the interrupt flag (0x11) and the enable (0x12) read 0, and the error counter is 0.
- R2: A falling edge on lock_i sets oof_o at the next clock edge. The status register at 0x10 then shows OOF in bit 4.
- R3: OOF is cleared only by a rising edge of lock_i, one clock after that edge. A lock_i level that stays high after a reframe does not clear it.
- R4: Each change of the OOF state, in either direction, sets the interrupt flag (bit 0 of 0x11) on the same edge. A reframe while OOF is already set does not change the state and does not set the flag.
- R5: irq_o equals the interrupt flag ANDed with bit 0 of 0x12. A read of 0x11 returns the flag in bit 0 and clears it, unless a new change occurs on the same edge.
- R6: Writing 1 to bit 0 of 0x01 produces reframe_o high for exactly one cycle. OOF is set on the same edge, and bit 0 reads back 0.
- R7: In the control register, bits 7 and 5..1 are read/write and appear on cfg_o. Bit 6 and bit 0 always read 0.
- R8: Register 0x10 reads {ais_i, los_i, idle_i, oof, 4'b0000} (bit 7 down to 0). Writes to it have no effect.
- R9: Each cycle with ferr_i high adds one to the error count. A read of 0x52 returns the count's high byte, stores the full count in a snapshot and clears the count. A read of 0x53 returns the low byte of that snapshot.
- R10: An error pulse in the same cycle as a 0x52 read is not lost. It becomes the first count of the new period.
- R11: The error count saturates at 0xFFFF and does not wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| lock_i | input | 1 | Framer core in-frame level |
| ferr_i | input | 1 | One error per cycle high: framing-bit (F or M) error |
| ais_i | input | 1 | AIS status from alarm logic |
| los_i | input | 1 | LOS status from alarm logic |
| idle_i | input | 1 | Idle-signal status from alarm logic |
| bus_cs_i | input | 1 | Register access strobe, one cycle per access |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 8 | Register address |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data, combinational from the address |
| reframe_o | output | 1 | One-cycle reframe command to the core |
| oof_o | output | 1 | Out-of-frame pin |
| irq_o | output | 1 | Change-of-OOF interrupt |
| cfg_o | output | 8 | Line control bits of register 0x01 |

## Verification
The bench builds the block with its default parameters: a 16-bit counter on an 8-bit bus, control reset value 0xA0 and write mask 0xBE. A 16-bit counter saturates after 65,535 error pulses, so the bench drives ferr_i without a break past that point and checks that both bytes read 0xFF. It also checks that the next read period starts from zero. Because the bus width is half the counter width, the snapshot split between the 0x52 and 0x53 reads can be exercised exactly, including an error that arrives on the same edge as the snapshot.

// File: rtl/ds3_frm_pkg.sv
package ds3_frm_pkg;
  localparam logic [7:0] ADDR_CTRL   = 8'h01;
  localparam logic [7:0] ADDR_STAT   = 8'h10;
  localparam logic [7:0] ADDR_ISR    = 8'h11;
  localparam logic [7:0] ADDR_IER    = 8'h12;
  localparam logic [7:0] ADDR_ERR_HI = 8'h52;
  localparam logic [7:0] ADDR_ERR_LO = 8'h53;

  typedef struct packed {
    logic ais;
    logic los;
    logic idle;
    logic oof;
  } rx_stat_t;
endpackage

// File: rtl/ds3_oof_tracker.sv
module ds3_oof_tracker (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lock_i,
  input  logic force_i,
  output logic oof_o,
  output logic chg_o
);
  logic lock_q, oof_q, oof_d;

  always_comb begin
    oof_d = oof_q;
    if (lock_q && !lock_i)      oof_d = 1'b1;
    else if (!lock_q && lock_i) oof_d = 1'b0;
    if (force_i)                oof_d = 1'b1;  // reframe wins
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lock_q <= 1'b0;
      oof_q  <= 1'b1;
    end else begin
      lock_q <= lock_i;
      oof_q  <= oof_d;
    end
  end

  assign oof_o = oof_q;
  assign chg_o = oof_d != oof_q;
endmodule

// File: rtl/ds3_ferr_counter.sv
module ds3_ferr_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ferr_i,
  input  logic             snap_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] snap_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q, snap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      snap_q <= '0;
    end else if (snap_i) begin
      snap_q <= cnt_q;
      cnt_q  <= CNT_W'(ferr_i);  // same-cycle error opens the new period
    end else if (ferr_i && cnt_q != CNT_MAX) begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assign cnt_o  = cnt_q;
  assign snap_o = snap_q;
endmodule

// File: rtl/ds3_frm_regs.sv
module ds3_frm_regs
  import ds3_frm_pkg::*;
#(
  parameter int unsigned    DW         = 8,
  parameter int unsigned    AW         = 8,
  parameter int unsigned    CNT_W      = 16,
  parameter logic [DW-1:0]  CTRL_RST   = 8'hA0,
  parameter logic [DW-1:0]  CTRL_WMASK = 8'hBE
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cs_i,
  input  logic             we_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [DW-1:0]    rdata_o,
  input  rx_stat_t         stat_i,
  input  logic             chg_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] snap_i,
  output logic             reframe_req_o,
  output logic             reframe_o,
  output logic             snap_req_o,
  output logic [DW-1:0]    cfg_o,
  output logic             irq_flag_o,
  output logic             irq_en_o,
  output logic             irq_o
);
  localparam logic [DW-1:0] RD_MASK = CTRL_WMASK & ~DW'(1);

  logic [DW-1:0] ctrl_q;
  logic          flag_q, en_q, reframe_q;
  logic          wr, rd;

  assign wr = cs_i && we_i;
  assign rd = cs_i && !we_i;

  assign reframe_req_o = wr && addr_i == AW'(ADDR_CTRL) && wdata_i[0];
  assign snap_req_o    = rd && addr_i == AW'(ADDR_ERR_HI);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q    <= CTRL_RST & RD_MASK;
      flag_q    <= 1'b0;
      en_q      <= 1'b0;
      reframe_q <= 1'b0;
    end else begin
      reframe_q <= reframe_req_o;
      if (wr && addr_i == AW'(ADDR_CTRL))
        ctrl_q <= (ctrl_q & ~RD_MASK) | (wdata_i & RD_MASK);
      if (wr && addr_i == AW'(ADDR_IER))
        en_q <= wdata_i[0];
      if (chg_i)
        flag_q <= 1'b1;
      else if (rd && addr_i == AW'(ADDR_ISR))
        flag_q <= 1'b0;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (rd) begin
      unique case (addr_i)
        AW'(ADDR_CTRL):   rdata_o = ctrl_q;
        AW'(ADDR_STAT):   rdata_o = {stat_i, {(DW-4){1'b0}}};
        AW'(ADDR_ISR):    rdata_o = {{(DW-1){1'b0}}, flag_q};
        AW'(ADDR_IER):    rdata_o = {{(DW-1){1'b0}}, en_q};
        AW'(ADDR_ERR_HI): rdata_o = cnt_i[CNT_W-1 -: DW];
        AW'(ADDR_ERR_LO): rdata_o = snap_i[DW-1:0];
        default:          rdata_o = '0;
      endcase
    end
  end

  assign reframe_o  = reframe_q;
  assign cfg_o      = ctrl_q;
  assign irq_flag_o = flag_q;
  assign irq_en_o   = en_q;
  assign irq_o      = flag_q && en_q;
endmodule

// File: rtl/ds3_frm_status.sv
module ds3_frm_status
  import ds3_frm_pkg::*;
#(
  parameter int unsigned   DW         = 8,
  parameter int unsigned   AW         = 8,
  parameter int unsigned   CNT_W      = 2 * DW,
  parameter logic [DW-1:0] CTRL_RST   = 8'hA0,
  parameter logic [DW-1:0] CTRL_WMASK = 8'hBE
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          lock_i,
  input  logic          ferr_i,
  input  logic          ais_i,
  input  logic          los_i,
  input  logic          idle_i,
  input  logic          bus_cs_i,
  input  logic          bus_we_i,
  input  logic [AW-1:0] bus_addr_i,
  input  logic [DW-1:0] bus_wdata_i,
  output logic [DW-1:0] bus_rdata_o,
  output logic          reframe_o,
  output logic          oof_o,
  output logic          irq_o,
  output logic [DW-1:0] cfg_o
);
  logic             reframe_req, snap_req, oof_chg, irq_flag, irq_en;
  logic [CNT_W-1:0] err_cnt, err_snap;
  rx_stat_t         stat;

  assign stat = '{ais: ais_i, los: los_i, idle: idle_i, oof: oof_o};

  ds3_oof_tracker u_oof (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .lock_i  (lock_i),
    .force_i (reframe_req),
    .oof_o   (oof_o),
    .chg_o   (oof_chg)
  );

  ds3_ferr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ferr_i (ferr_i),
    .snap_i (snap_req),
    .cnt_o  (err_cnt),
    .snap_o (err_snap)
  );

  ds3_frm_regs #(
    .DW(DW), .AW(AW), .CNT_W(CNT_W), .CTRL_RST(CTRL_RST), .CTRL_WMASK(CTRL_WMASK)
  ) u_regs (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .cs_i          (bus_cs_i),
    .we_i          (bus_we_i),
    .addr_i        (bus_addr_i),
    .wdata_i       (bus_wdata_i),
    .rdata_o       (bus_rdata_o),
    .stat_i        (stat),
    .chg_i         (oof_chg),
    .cnt_i         (err_cnt),
    .snap_i        (err_snap),
    .reframe_req_o (reframe_req),
    .reframe_o     (reframe_o),
    .snap_req_o    (snap_req),
    .cfg_o         (cfg_o),
    .irq_flag_o    (irq_flag),
    .irq_en_o      (irq_en),
    .irq_o         (irq_o)
  );
endmodule

// File: rtl/ds3_frm_status_chk.sv
module ds3_frm_status_chk #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             lock_i,
  input logic             ferr_i,
  input logic             oof_o,
  input logic             reframe_o,
  input logic             irq_o,
  input logic             irq_flag_i,
  input logic             irq_en_i,
  input logic             snap_req_i,
  input logic [CNT_W-1:0] cnt_i
);
  AST_OOF_ON_LOCK_LOSS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(lock_i) |=> oof_o); // R2
  AST_FLAG_ON_CHANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oof_o != $past(oof_o)) |-> irq_flag_i); // R4
  AST_IRQ_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (irq_flag_i && irq_en_i)); // R5
  AST_REFRAME_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reframe_o |=> !reframe_o); // R6
  AST_REFRAME_OOF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reframe_o |-> oof_o); // R6
  AST_SNAP_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snap_req_i |=> (cnt_i == CNT_W'($past(ferr_i)))); // R10
  AST_NO_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_i == {CNT_W{1'b1}} && !snap_req_i) |=> (cnt_i == {CNT_W{1'b1}})); // R11
endmodule

bind ds3_frm_status ds3_frm_status_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .lock_i     (lock_i),
  .ferr_i     (ferr_i),
  .oof_o      (oof_o),
  .reframe_o  (reframe_o),
  .irq_o      (irq_o),
  .irq_flag_i (irq_flag),
  .irq_en_i   (irq_en),
  .snap_req_i (snap_req),
  .cnt_i      (err_cnt)
);

// File: tb/ds3_frm_status_tb.sv
module ds3_frm_status_tb;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       lock_i = 1'b0, ferr_i = 1'b0;
  logic       ais_i = 1'b0, los_i = 1'b0, idle_i = 1'b0;
  logic       bus_cs_i = 1'b0, bus_we_i = 1'b0;
  logic [7:0] bus_addr_i = '0, bus_wdata_i = '0;
  logic [7:0] bus_rdata_o, cfg_o;
  logic       reframe_o, oof_o, irq_o;
  int         n_chk = 0, n_err = 0;

  always #2 clk = ~clk;

  ds3_frm_status u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .lock_i(lock_i), .ferr_i(ferr_i),
    .ais_i(ais_i), .los_i(los_i), .idle_i(idle_i),
    .bus_cs_i(bus_cs_i), .bus_we_i(bus_we_i), .bus_addr_i(bus_addr_i),
    .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o),
    .reframe_o(reframe_o), .oof_o(oof_o), .irq_o(irq_o), .cfg_o(cfg_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // all tasks start and end at a falling edge
  task automatic bus_rd(input logic [7:0] a, output logic [7:0] d);
    bus_cs_i = 1'b1; bus_we_i = 1'b0; bus_addr_i = a;
    #1 d = bus_rdata_o;
    @(negedge clk);
    bus_cs_i = 1'b0;
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [7:0] d);
    bus_cs_i = 1'b1; bus_we_i = 1'b1; bus_addr_i = a; bus_wdata_i = d;
    @(negedge clk);
    bus_cs_i = 1'b0; bus_we_i = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [7:0] exp);
    logic [7:0] d;
    bus_rd(a, d);
    check(req, {24'h0, d}, {24'h0, exp});
  endtask

  task automatic errs(input int n);
    ferr_i = 1'b1;
    repeat (n) @(negedge clk);
    ferr_i = 1'b0;
  endtask

  task automatic t_reset;
    check("R1 oof", oof_o, 1);
    check("R1 irq", irq_o, 0);
    check("R1 reframe", reframe_o, 0);
    rd_chk("R1 ctrl", 8'h01, 8'hA0);
    rd_chk("R1 stat", 8'h10, 8'h10);
    rd_chk("R1 isr", 8'h11, 8'h00);
    rd_chk("R1 ier", 8'h12, 8'h00);
    rd_chk("R1 cnt hi", 8'h52, 8'h00);
    rd_chk("R1 cnt lo", 8'h53, 8'h00);
  endtask

  task automatic t_acquire;
    lock_i = 1'b1;
    @(negedge clk);
    check("R3 oof cleared on lock", oof_o, 0);
    check("R5 irq masked", irq_o, 0);
    rd_chk("R4 flag on exit", 8'h11, 8'h01);
    rd_chk("R5 flag cleared by read", 8'h11, 8'h00);
  endtask

  task automatic t_loss;
    bus_wr(8'h12, 8'h01);
    lock_i = 1'b0;
    @(negedge clk);
    check("R2 oof on lock loss", oof_o, 1);
    check("R5 irq enabled", irq_o, 1);
    rd_chk("R2 stat bit4", 8'h10, 8'h10);
    rd_chk("R4 flag on entry", 8'h11, 8'h01);
    check("R5 irq after clear", irq_o, 0);
  endtask

  task automatic t_reframe;
    lock_i = 1'b1;
    @(negedge clk);
    rd_chk("R3 isr clear", 8'h11, 8'h01);
    check("R3 in frame", oof_o, 0);
    bus_wr(8'h01, 8'hA1);
    check("R6 reframe pulse", reframe_o, 1);
    check("R6 oof forced", oof_o, 1);
    check("R4 irq on reframe", irq_o, 1);
    @(negedge clk);
    check("R6 pulse one cycle", reframe_o, 0);
    check("R3 lock level keeps oof", oof_o, 1);
    rd_chk("R6 bit0 reads 0", 8'h01, 8'hA0);
    rd_chk("R4 isr after reframe", 8'h11, 8'h01);
    bus_wr(8'h01, 8'hA1);
    @(negedge clk);
    rd_chk("R4 no flag when already oof", 8'h11, 8'h00);
    lock_i = 1'b0;
    @(negedge clk);
    lock_i = 1'b1;
    @(negedge clk);
    check("R3 reacquire", oof_o, 0);
    rd_chk("R4 isr reacquire", 8'h11, 8'h01);
  endtask

  task automatic t_ctrl;
    bus_wr(8'h01, 8'h5E);
    rd_chk("R7 ctrl masked", 8'h01, 8'h1E);
    check("R7 cfg_o", cfg_o, 8'h1E);
    bus_wr(8'h01, 8'hE0);
    rd_chk("R7 ctrl high bits", 8'h01, 8'hA0);
  endtask

  task automatic t_status;
    ais_i = 1'b1; los_i = 1'b1;
    rd_chk("R8 ais los", 8'h10, 8'hC0);
    bus_wr(8'h10, 8'hFF);
    rd_chk("R8 write ignored", 8'h10, 8'hC0);
    idle_i = 1'b1; ais_i = 1'b0;
    rd_chk("R8 idle", 8'h10, 8'h60);
    los_i = 1'b0; idle_i = 1'b0;
  endtask

  task automatic t_count;
    logic [7:0] d;
    errs(5);
    rd_chk("R9 hi 5", 8'h52, 8'h00);
    rd_chk("R9 lo 5", 8'h53, 8'h05);
    rd_chk("R9 hi cleared", 8'h52, 8'h00);
    rd_chk("R9 lo cleared", 8'h53, 8'h00);
    errs(3);
    ferr_i = 1'b1;
    bus_rd(8'h52, d);
    ferr_i = 1'b0;
    check("R10 hi", d, 8'h00);
    rd_chk("R10 lo snapshot", 8'h53, 8'h03);
    rd_chk("R10 hi next", 8'h52, 8'h00);
    rd_chk("R10 carried error", 8'h53, 8'h01);
    errs(300);
    rd_chk("R9 hi 300", 8'h52, 8'h01);
    rd_chk("R9 lo 300", 8'h53, 8'h2C);
  endtask

  task automatic t_saturate;
    errs(65540);
    rd_chk("R11 hi sat", 8'h52, 8'hFF);
    rd_chk("R11 lo sat", 8'h53, 8'hFF);
    rd_chk("R11 hi restart", 8'h52, 8'h00);
    rd_chk("R11 lo restart", 8'h53, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_acquire();
    t_loss();
    t_reframe();
    t_ctrl();
    t_status();
    t_count();
    t_saturate();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule